// File: doc/BRIEF.md
# Vectored Interrupt Controller with Daisy-Chain Input

This block collects a set of level-sensitive interrupt sources (32 by default) and steers each one to either a fast interrupt output or a normal interrupt output. Both outputs are active low. A source takes part only when it is enabled. Software can force any source active. The normal path is vectored. Every source has a programmable 4-bit priority and its own 32-bit handler address. The controller presents the address of the best pending normal interrupt to the processor at all times.

When the processor takes an interrupt, the controller records that priority level as in service. The processor does this either by reading the vector register or by raising the acknowledge line. From then on, only strictly more urgent interrupts can raise the normal output. This holds until software writes the vector register to end service. An upstream controller can be chained in. Its normal request competes at a programmable priority. If it wins, its vector address is passed through and the acknowledge is forwarded back to it. Its fast request is merged directly.

Registers sit on a simple single-cycle bus. Read data is combinational from the address. Writes take effect at the clock edge. A protection bit restricts writes to privileged accesses.

Top module: `vic_top`

## Requirements
- R1: After reset the following hold. Enable (0x010), select (0x00C), soft (0x018) and protection (0x020) read 0. The level mask (0x024) reads 0x0000FFFF. The chain priority (0x028) reads 0xF. Every priority register reads 0xF. irq_n_o and fiq_n_o are 1 and vaddr_o is 0.
- R2: Raw status (0x008) equals src_i OR the soft bits. Writing 1s to 0x018 sets soft bits. Writing 1s to 0x01C clears them. A 0 written to either address leaves the corresponding bit unchanged.
- R3: Writing 1s to 0x010 sets enable bits. Writing 1s to 0x01C-neighbour 0x014 clears them. A 0 written to either address has no effect. 0x010 reads back the enable bits.
- R4: The normal status (0x000) is raw AND enable AND NOT select. The fast status (0x004) is raw AND enable AND select. The select register sets a bit to 1 for the fast path.
- R5: fiq_n_o is 0 exactly when any fast status bit is set or dc_fiq_n_i is 0. Fast sources never affect irq_n_o or vaddr_o.
- R6: irq_n_o is 0 exactly when an eligible normal candidate exists. The winner has the numerically lowest priority, with 0 as most urgent. Among equal priorities the lowest index wins. vaddr_o carries the winner's vector register (0x100 + 4*i) and is 0 when irq_n_o is 1.
- R7: Bit L of the level mask (0x024), when 0, removes every candidate at priority L, including the chained request.
- R8: dc_irq_n_i = 0 forms a candidate at the chain priority (0x028). If it wins, vaddr_o equals dc_vaddr_i. A source at the same priority beats it.
- R9: ack_o is 1 only while ack_i is 1 and the chained candidate is the current winner.
- R10: Reading 0xF00 returns vaddr_o. That read, or ack_i, while irq_n_o is 0 marks the winner's level as in service. While any level is in service, only priorities strictly below the most urgent in-service level are candidates.
- R11: Any write to 0xF00 ends service of the most urgent in-service level.
- R12: With bit 0 of 0x020 set, writes with bus_priv_i = 0 change nothing.
- R13: Priority registers (0x200 + 4*i) keep and return only bits [3:0]. Vector registers keep and return all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Interrupt source levels |
| bus_req_i | input | 1 | Bus access valid |
| bus_we_i | input | 1 | Bus write when 1, read when 0 |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_priv_i | input | 1 | Access is privileged |
| bus_rdata_o | output | 32 | Read data, combinational |
| dc_irq_n_i | input | 1 | Upstream normal request, active low |
| dc_fiq_n_i | input | 1 | Upstream fast request, active low |
| dc_vaddr_i | input | 32 | Upstream vector address |
| ack_i | input | 1 | Acknowledge from processor or next stage |
| ack_o | output | 1 | Acknowledge forwarded upstream |
| vaddr_o | output | 32 | Vector address of current winner |
| irq_n_o | output | 1 | Normal interrupt, active low |
| fiq_n_o | output | 1 | Fast interrupt, active low |

## Verification
The assertions check on every cycle that the upstream fast request always reaches fiq_n_o and that vaddr_o is zero with no request. They also check that ack_o appears only with the chained vector on the output, and that the winner is always more urgent than the in-service ceiling. A further check is that a service mark or an end-of-service write moves that ceiling the right way. The correctness of the winner choice itself can only be shown by the bench's scenarios. That covers priority ties, masking, the enable and select split and the protection gate. The bench drives randomised priority sets, with exhaustive readback of every per-source register, against a model built from the requirements.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned PRIO_W   = 4;
  localparam int unsigned N_LVL    = 1 << PRIO_W;
  localparam int unsigned BUS_AW   = 12;
  localparam int unsigned BUS_DW   = 32;
  localparam int unsigned PAGE_LSB = 8;
  localparam int unsigned IDX_W    = PAGE_LSB - 2;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [PRIO_W:0]   ceil_t;

  localparam logic [BUS_AW-1:0] A_IRQ     = 12'h000;
  localparam logic [BUS_AW-1:0] A_FIQ     = 12'h004;
  localparam logic [BUS_AW-1:0] A_RAW     = 12'h008;
  localparam logic [BUS_AW-1:0] A_SEL     = 12'h00C;
  localparam logic [BUS_AW-1:0] A_EN      = 12'h010;
  localparam logic [BUS_AW-1:0] A_ENCLR   = 12'h014;
  localparam logic [BUS_AW-1:0] A_SOFT    = 12'h018;
  localparam logic [BUS_AW-1:0] A_SOFTCLR = 12'h01C;
  localparam logic [BUS_AW-1:0] A_PROT    = 12'h020;
  localparam logic [BUS_AW-1:0] A_MASK    = 12'h024;
  localparam logic [BUS_AW-1:0] A_DCPRI   = 12'h028;
  localparam logic [BUS_AW-1:0] A_VECT    = 12'hF00;

  localparam logic [BUS_AW-PAGE_LSB-1:0] PG_VEC = 4'h1;
  localparam logic [BUS_AW-PAGE_LSB-1:0] PG_PRI = 4'h2;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [BUS_AW-1:0]              addr_i,
  input  logic [BUS_DW-1:0]              wdata_i,
  input  logic                           priv_i,
  input  logic [N_SRC-1:0]               src_i,
  input  logic [BUS_DW-1:0]              vect_cur_i,
  output logic [BUS_DW-1:0]              rdata_o,
  output logic [N_SRC-1:0]               irq_stat_o,
  output logic [N_SRC-1:0]               fiq_stat_o,
  output logic [N_LVL-1:0]               mask_o,
  output prio_t                          dc_prio_o,
  output prio_t [N_SRC-1:0]              prio_o,
  output logic [N_SRC-1:0][BUS_DW-1:0]   vaddr_o,
  output logic                           eoi_o,
  output logic                           vread_o
);
  logic [N_SRC-1:0] sel_q, en_q, soft_q, raw;
  logic             prot_q;
  logic [N_LVL-1:0] mask_q;
  prio_t            dc_prio_q;
  prio_t [N_SRC-1:0]            prio_q;
  logic [N_SRC-1:0][BUS_DW-1:0] vaddr_q;

  logic                         wr_ok;
  logic [BUS_AW-PAGE_LSB-1:0]   page;
  logic [IDX_W-1:0]             idx;

  assign wr_ok = req_i & we_i & (~prot_q | priv_i);
  assign page  = addr_i[BUS_AW-1:PAGE_LSB];
  assign idx   = addr_i[PAGE_LSB-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= '0;
      en_q      <= '0;
      soft_q    <= '0;
      prot_q    <= 1'b0;
      mask_q    <= '1;
      dc_prio_q <= '1;
    end else if (wr_ok) begin
      case (addr_i)
        A_SEL:     sel_q     <= wdata_i[N_SRC-1:0];
        A_EN:      en_q      <= en_q | wdata_i[N_SRC-1:0];
        A_ENCLR:   en_q      <= en_q & ~wdata_i[N_SRC-1:0];
        A_SOFT:    soft_q    <= soft_q | wdata_i[N_SRC-1:0];
        A_SOFTCLR: soft_q    <= soft_q & ~wdata_i[N_SRC-1:0];
        A_PROT:    prot_q    <= wdata_i[0];
        A_MASK:    mask_q    <= wdata_i[N_LVL-1:0];
        A_DCPRI:   dc_prio_q <= wdata_i[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q <= '0;
      prio_q  <= '1;
    end else if (wr_ok) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (page == PG_VEC && idx == IDX_W'(i)) vaddr_q[i] <= wdata_i;
        if (page == PG_PRI && idx == IDX_W'(i)) prio_q[i]  <= wdata_i[PRIO_W-1:0];
      end
    end
  end

  assign raw        = src_i | soft_q;
  assign irq_stat_o = raw & en_q & ~sel_q;
  assign fiq_stat_o = raw & en_q & sel_q;
  assign mask_o     = mask_q;
  assign dc_prio_o  = dc_prio_q;
  assign prio_o     = prio_q;
  assign vaddr_o    = vaddr_q;
  assign vread_o    = req_i & ~we_i & (addr_i == A_VECT);
  assign eoi_o      = wr_ok & (addr_i == A_VECT);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_IRQ:  rdata_o[N_SRC-1:0]  = irq_stat_o;
      A_FIQ:  rdata_o[N_SRC-1:0]  = fiq_stat_o;
      A_RAW:  rdata_o[N_SRC-1:0]  = raw;
      A_SEL:  rdata_o[N_SRC-1:0]  = sel_q;
      A_EN:   rdata_o[N_SRC-1:0]  = en_q;
      A_SOFT: rdata_o[N_SRC-1:0]  = soft_q;
      A_PROT: rdata_o[0]          = prot_q;
      A_MASK: rdata_o[N_LVL-1:0]  = mask_q;
      A_DCPRI: rdata_o[PRIO_W-1:0] = dc_prio_q;
      A_VECT: rdata_o             = vect_cur_i;
      default: begin
        for (int i = 0; i < N_SRC; i++) begin
          if (page == PG_VEC && idx == IDX_W'(i)) rdata_o = vaddr_q[i];
          if (page == PG_PRI && idx == IDX_W'(i)) rdata_o[PRIO_W-1:0] = prio_q[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/vic_arb.sv
module vic_arb
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic [N_SRC-1:0]             irq_stat_i,
  input  prio_t [N_SRC-1:0]            prio_i,
  input  logic [N_SRC-1:0][BUS_DW-1:0] vaddr_i,
  input  logic [N_LVL-1:0]             mask_i,
  input  ceil_t                        ceil_i,
  input  logic                         dc_req_i,
  input  prio_t                        dc_prio_i,
  input  logic [BUS_DW-1:0]            dc_vaddr_i,
  output logic                         req_o,
  output prio_t                        win_prio_o,
  output logic [BUS_DW-1:0]            win_vaddr_o,
  output logic                         win_dc_o
);
  ceil_t best;

  // best starts at the service ceiling: strict compare gives both the
  // ceiling rule and lowest-index tie break
  always_comb begin
    best        = ceil_i;
    req_o       = 1'b0;
    win_vaddr_o = '0;
    win_dc_o    = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (irq_stat_i[i] && mask_i[prio_i[i]] && ({1'b0, prio_i[i]} < best)) begin
        best        = {1'b0, prio_i[i]};
        req_o       = 1'b1;
        win_vaddr_o = vaddr_i[i];
      end
    end
    if (dc_req_i && mask_i[dc_prio_i] && ({1'b0, dc_prio_i} < best)) begin
      best        = {1'b0, dc_prio_i};
      req_o       = 1'b1;
      win_vaddr_o = dc_vaddr_i;
      win_dc_o    = 1'b1;
    end
    win_prio_o = best[PRIO_W-1:0];
  end
endmodule

// File: rtl/vic_stack.sv
module vic_stack
  import vic_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  prio_t push_lvl_i,
  input  logic  pop_i,
  output ceil_t ceil_o
);
  logic [N_LVL-1:0] active_q, active_d;

  // levels only nest toward higher urgency, so a bit set suffices as a stack
  always_comb begin
    active_d = pop_i ? (active_q & (active_q - 1'b1)) : active_q;
    if (push_i) active_d[push_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= '0;
    else         active_q <= active_d;
  end

  always_comb begin
    ceil_o = ceil_t'(N_LVL);
    for (int l = N_LVL - 1; l >= 0; l--) begin
      if (active_q[l]) ceil_o = ceil_t'(l);
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  input  logic              bus_priv_i,
  output logic [BUS_DW-1:0] bus_rdata_o,
  input  logic              dc_irq_n_i,
  input  logic              dc_fiq_n_i,
  input  logic [BUS_DW-1:0] dc_vaddr_i,
  input  logic              ack_i,
  output logic              ack_o,
  output logic [BUS_DW-1:0] vaddr_o,
  output logic              irq_n_o,
  output logic              fiq_n_o
);
  logic [N_SRC-1:0]             irq_stat, fiq_stat;
  logic [N_LVL-1:0]             mask;
  prio_t                        dc_prio, win_prio;
  prio_t [N_SRC-1:0]            prio;
  logic [N_SRC-1:0][BUS_DW-1:0] vaddr_tab;
  logic                         eoi, vread, arb_req, win_dc, push;
  logic [BUS_DW-1:0]            win_vaddr;
  ceil_t                        ceil;

  vic_regs #(.N_SRC(N_SRC)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (bus_req_i),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .priv_i     (bus_priv_i),
    .src_i      (src_i),
    .vect_cur_i (win_vaddr),
    .rdata_o    (bus_rdata_o),
    .irq_stat_o (irq_stat),
    .fiq_stat_o (fiq_stat),
    .mask_o     (mask),
    .dc_prio_o  (dc_prio),
    .prio_o     (prio),
    .vaddr_o    (vaddr_tab),
    .eoi_o      (eoi),
    .vread_o    (vread)
  );

  vic_arb #(.N_SRC(N_SRC)) u_arb (
    .irq_stat_i  (irq_stat),
    .prio_i      (prio),
    .vaddr_i     (vaddr_tab),
    .mask_i      (mask),
    .ceil_i      (ceil),
    .dc_req_i    (~dc_irq_n_i),
    .dc_prio_i   (dc_prio),
    .dc_vaddr_i  (dc_vaddr_i),
    .req_o       (arb_req),
    .win_prio_o  (win_prio),
    .win_vaddr_o (win_vaddr),
    .win_dc_o    (win_dc)
  );

  assign push = (vread | ack_i) & arb_req;

  vic_stack u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_lvl_i (win_prio),
    .pop_i      (eoi),
    .ceil_o     (ceil)
  );

  assign irq_n_o = ~arb_req;
  assign vaddr_o = win_vaddr;
  assign ack_o   = ack_i & arb_req & win_dc;
  assign fiq_n_o = ~((|fiq_stat) | ~dc_fiq_n_i);
endmodule

// File: rtl/vic_chk.sv
module vic_chk
  import vic_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_n_i,
  input logic              fiq_n_i,
  input logic              dc_irq_n_i,
  input logic              dc_fiq_n_i,
  input logic [BUS_DW-1:0] dc_vaddr_i,
  input logic [BUS_DW-1:0] vaddr_i,
  input logic              ack_in_i,
  input logic              ack_out_i,
  input logic              push_i,
  input logic              eoi_i,
  input prio_t             win_prio_i,
  input ceil_t             ceil_i
);
  p_fiq_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dc_fiq_n_i |-> !fiq_n_i);

  p_idle_vaddr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_n_i |-> (vaddr_i == '0));

  p_ack_fwd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_out_i |-> (ack_in_i && !irq_n_i && !dc_irq_n_i && vaddr_i == dc_vaddr_i));

  p_under_ceil_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_n_i |-> ({1'b0, win_prio_i} < ceil_i));

  p_push_lvl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (ceil_i == $past({1'b0, win_prio_i})));

  p_pop_lvl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !push_i && ceil_i != ceil_t'(N_LVL)) |=> (ceil_i > $past(ceil_i)));
endmodule

bind vic_top vic_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_n_i    (irq_n_o),
  .fiq_n_i    (fiq_n_o),
  .dc_irq_n_i (dc_irq_n_i),
  .dc_fiq_n_i (dc_fiq_n_i),
  .dc_vaddr_i (dc_vaddr_i),
  .vaddr_i    (vaddr_o),
  .ack_in_i   (ack_i),
  .ack_out_i  (ack_o),
  .push_i     (push),
  .eoi_i      (eoi),
  .win_prio_i (win_prio),
  .ceil_i     (ceil)
);

// File: tb/tb_vic_top.sv
module tb_vic_top;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic        req = 1'b0, we = 1'b0, priv = 1'b1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        dc_irq_n = 1'b1, dc_fiq_n = 1'b1;
  logic [31:0] dc_vaddr = 32'hDC00_0000;
  logic        ack = 1'b0, ack_o, irq_n, fiq_n;
  logic [31:0] vaddr;

  always #2 clk = ~clk;

  vic_top #(.N_SRC(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_priv_i(priv), .bus_rdata_o(rdata),
    .dc_irq_n_i(dc_irq_n), .dc_fiq_n_i(dc_fiq_n), .dc_vaddr_i(dc_vaddr),
    .ack_i(ack), .ack_o(ack_o), .vaddr_o(vaddr), .irq_n_o(irq_n), .fiq_n_o(fiq_n)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // requirement-level shadow state
  int          sh_prio [N];
  logic [31:0] sh_vaddr[N];
  logic [N-1:0] sh_en = '0, sh_sel = '0, sh_soft = '0;
  logic [15:0] sh_mask = 16'hFFFF, sh_stack = '0;
  int          sh_dprio = 15;
  bit          sh_prot = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, bit p = 1);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; priv = p;
    @(negedge clk);
    req = 0; we = 0; priv = 1;
    if (!sh_prot || p) begin
      case (a)
        12'h00C: sh_sel = d;
        12'h010: sh_en = sh_en | d;
        12'h014: sh_en = sh_en & ~d;
        12'h018: sh_soft = sh_soft | d;
        12'h01C: sh_soft = sh_soft & ~d;
        12'h020: sh_prot = d[0];
        12'h024: sh_mask = d[15:0];
        12'h028: sh_dprio = int'(d[3:0]);
        12'hF00: sh_stack = sh_stack & (sh_stack - 16'd1);
        default: begin
          if (a[11:8] == 4'h1) sh_vaddr[a[7:2]] = d;
          if (a[11:8] == 4'h2) sh_prio[a[7:2]] = int'(d[3:0]);
        end
      endcase
    end
  endtask

  task automatic model(output bit irq, output logic [31:0] va, output bit dw, output int lv);
    int ceil = 16;
    int best;
    logic [N-1:0] raw = src | sh_soft;
    for (int l = 15; l >= 0; l--) if (sh_stack[l]) ceil = l;
    best = ceil; irq = 0; va = '0; dw = 0;
    for (int i = 0; i < N; i++)
      if (raw[i] && sh_en[i] && !sh_sel[i] && sh_mask[sh_prio[i]] && sh_prio[i] < best) begin
        best = sh_prio[i]; va = sh_vaddr[i]; irq = 1;
      end
    if (!dc_irq_n && sh_mask[sh_dprio] && sh_dprio < best) begin
      best = sh_dprio; va = dc_vaddr; irq = 1; dw = 1;
    end
    lv = best;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bit irq, dw; logic [31:0] va; int lv;
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    model(irq, va, dw, lv);
    @(negedge clk);
    req = 0;
    if (a == 12'hF00 && irq) sh_stack[lv] = 1'b1;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic exp_out(string tag);
    bit irq, dw; logic [31:0] va; int lv;
    logic [N-1:0] fs;
    #1;
    model(irq, va, dw, lv);
    fs = (src | sh_soft) & sh_en & sh_sel;
    chk({tag, " irq_n"}, 32'(irq_n), 32'(!irq));
    chk({tag, " vaddr"}, vaddr, irq ? va : 32'h0);
    chk({tag, " fiq_n"}, 32'(fiq_n), 32'(!((|fs) || !dc_fiq_n)));
  endtask

  task automatic ack_pulse(string tag);
    bit irq, dw; logic [31:0] va; int lv;
    @(negedge clk);
    ack = 1;
    #1 model(irq, va, dw, lv);
    chk({tag, " ack_o"}, 32'(ack_o), 32'(irq && dw));
    @(negedge clk);
    ack = 0;
    if (irq) sh_stack[lv] = 1'b1;
  endtask

  task automatic pop_all(string tag);
    while (sh_stack != 0) begin
      wr(12'hF00, 32'h0);
      exp_out(tag);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < N; i++) begin sh_prio[i] = 15; sh_vaddr[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    rd_chk("R1 enable", 12'h010, 0);
    rd_chk("R1 select", 12'h00C, 0);
    rd_chk("R1 soft", 12'h018, 0);
    rd_chk("R1 prot", 12'h020, 0);
    rd_chk("R1 mask", 12'h024, 32'h0000_FFFF);
    rd_chk("R1 dcprio", 12'h028, 32'hF);
    for (int i = 0; i < N; i++) rd_chk("R1 prio", 12'(12'h200 + 4 * i), 32'hF);
    #1;
    chk("R1 irq_n", 32'(irq_n), 1);
    chk("R1 fiq_n", 32'(fiq_n), 1);
    chk("R1 vaddr", vaddr, 0);

    // R13 per-source register readback
    for (int i = 0; i < N; i++) begin
      wr(12'(12'h100 + 4 * i), 32'h8000_0000 + 32'(i) * 32'h44);
      wr(12'(12'h200 + 4 * i), 32'hFFFF_FFF0 | 32'((i * 7) % 16));
    end
    for (int i = 0; i < N; i++) begin
      rd_chk("R13 vect", 12'(12'h100 + 4 * i), 32'h8000_0000 + 32'(i) * 32'h44);
      rd_chk("R13 prio", 12'(12'h200 + 4 * i), 32'((i * 7) % 16));
    end

    // R2 raw / soft set-clear
    wr(12'h018, 32'hA5A5_0001);
    rd_chk("R2 soft set", 12'h008, 32'hA5A5_0001);
    wr(12'h018, 32'h0);
    rd_chk("R2 soft zero write", 12'h008, 32'hA5A5_0001);
    src = 32'h0F00_0000;
    rd_chk("R2 raw or", 12'h008, 32'hAFA5_0001);
    wr(12'h01C, 32'h0000_0001);
    rd_chk("R2 soft clear", 12'h008, 32'hAFA5_0000);
    wr(12'h01C, 32'hFFFF_FFFF);
    src = '0;
    rd_chk("R2 all clear", 12'h008, 0);

    // R3 enable set-clear
    wr(12'h010, 32'h0000_00FF);
    wr(12'h010, 32'h0000_FF00);
    rd_chk("R3 set", 12'h010, 32'h0000_FFFF);
    wr(12'h014, 32'h0000_0F0F);
    rd_chk("R3 clear", 12'h010, 32'h0000_F0F0);
    wr(12'h014, 32'h0);
    rd_chk("R3 zero clear", 12'h010, 32'h0000_F0F0);
    wr(12'h014, 32'hFFFF_FFFF);
    rd_chk("R3 all clear", 12'h010, 0);

    // R4 / R5 select split and fast path
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h00C, 32'hFFFF_0000);
    wr(12'h018, 32'h0001_0001);
    rd_chk("R4 irq stat", 12'h000, 32'h0000_0001);
    rd_chk("R4 fiq stat", 12'h004, 32'h0001_0000);
    exp_out("R5 fast src");
    wr(12'h01C, 32'h0000_0001);
    exp_out("R5 fast only no irq");
    wr(12'h01C, 32'h0001_0000);
    exp_out("R5 idle");
    dc_fiq_n = 0;
    exp_out("R5 upstream fast");
    dc_fiq_n = 1;
    wr(12'h00C, 32'h0);

    // R7 masking, R8 chain tie / win, R9 ack, R10 ceiling, R11 pop
    for (int i = 0; i < N; i++) wr(12'(12'h200 + 4 * i), 32'hF);
    wr(12'h200 + 12'd12, 32'd2);
    wr(12'h200 + 12'd36, 32'd5);
    wr(12'h018, 32'h0000_0208);
    exp_out("R6 min prio");
    wr(12'h024, 32'h0000_FFFB);
    exp_out("R7 level2 masked");
    wr(12'h024, 32'h0000_FFDB);
    exp_out("R7 both masked");
    wr(12'h024, 32'h0000_FFFF);
    wr(12'h01C, 32'h0000_0008);
    wr(12'h028, 32'd5);
    dc_irq_n = 0;
    exp_out("R8 tie source wins");
    ack_pulse("R9 source wins");
    exp_out("R10 level5 in service");
    pop_all("R11 pop");
    wr(12'h028, 32'd4);
    exp_out("R8 chain wins");
    ack_pulse("R9 chain wins");
    exp_out("R10 after ack");
    wr(12'h018, 32'h0000_0008);
    exp_out("R10 higher preempts");
    rd(12'hF00, d);
    chk("R10 vect read", d, sh_vaddr[3]);
    exp_out("R10 nested");
    pop_all("R11 nested pop");
    dc_irq_n = 1;
    wr(12'h01C, 32'hFFFF_FFFF);

    // R12 protection
    wr(12'h020, 32'h1);
    wr(12'h014, 32'hFFFF_FFFF, 0);
    rd_chk("R12 blocked", 12'h010, 32'hFFFF_FFFF);
    wr(12'h018, 32'h1, 0);
    exp_out("R12 blocked soft");
    wr(12'h014, 32'h0000_00FF, 1);
    rd_chk("R12 privileged", 12'h010, 32'hFFFF_FF00);
    wr(12'h020, 32'h0);
    wr(12'h010, 32'hFFFF_FFFF);

    // randomised sweep: R6 R7 R8 R9 R10 R11
    for (int it = 0; it < 150; it++) begin
      logic [31:0] r;
      for (int i = 0; i < N; i++)
        wr(12'(12'h200 + 4 * i), (it % 2) ? ($urandom & 32'h7) : ($urandom & 32'hF));
      wr(12'h00C, $urandom & 32'h0000_00FF);
      wr(12'h018, $urandom & $urandom & $urandom);
      wr(12'h024, (it % 3 == 0) ? $urandom : 32'h0000_FFFF);
      wr(12'h028, $urandom & 32'hF);
      dc_irq_n = ($urandom % 3) == 0;
      dc_vaddr = $urandom;
      src = (it % 4 == 0) ? ($urandom & $urandom) : '0;
      exp_out("R6 sweep");
      ack_pulse("R9 sweep");
      exp_out("R10 sweep after ack");
      rd(12'hF00, r);
      exp_out("R10 sweep after read");
      wr(12'h028, $urandom & 32'h3);
      exp_out("R8 sweep nested");
      pop_all("R11 sweep");
      wr(12'h01C, 32'hFFFF_FFFF);
      src = '0;
      dc_irq_n = 1;
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule